// File: doc/BRIEF.md
# Matrix keypad column scanner

This block scans a four-by-four key matrix. It drives exactly one of the four column lines high at any time. At each scan step it moves the active column to the next one. The four row lines are read back after a synchronizer. Each row has a pull-down, so a row reads high only when a closed key joins it to the column that is being driven.

When a scan step finds any row high, the scanner stops rotating and keeps that column driven. It latches a hex code for the key it has found and raises a held flag. It then waits until a scan step sees every row low again. After that it drops the flag and the rotation starts again.

The scan step rate is set outside the block through a one-cycle step enable. In the target system that is about 100 to 200 steps per second from a system clock near 20 MHz. Debounce timing and one-shot key registration belong to the logic that follows this block. The scanner only has to find a single key at a time. Several keys held together must never leave it stuck.

Top module: `keymatrix_scanner`

## Requirements
- R1: While reset is held and just after it is released, `col_drive` is 4'b0001 (column 0), `key_held` is 0 and `key_code` is 0.
- R2: With `key_held` low, each clock with `step_en` high moves the single high bit of `col_drive` from column c to column (c+1) mod 4, where bit c drives column c. In clocks without `step_en`, `col_drive` does not change. Exactly one bit of `col_drive` is high at all times.
- R3: When a step finds at least one synchronized row high, `key_held` rises and the column stays driven. After that, `col_drive` does not change for as long as `key_held` stays high, even if keys in other columns are pressed.
- R4: `key_code` gives the key at row r (bit r of `row_in`) and column c using the following layout. Row 0 is 1,2,3,A. Row 1 is 4,5,6,B. Row 2 is 7,8,9,C. Row 3 is E,0,F,D. The codes are hex values, with 4'hE for the star key and 4'hF for the hash key.
- R5: If more than one row is high in the column being scanned when a key is found, the code is taken from the lowest-numbered row.
- R6: `key_held` stays high while any row stays high. It falls after the first step that sees all rows low. From the next step on, rotation goes on from the column that was frozen.
- R7: Holding keys in two columns never hangs the scanner. When the held key is released while a key in another column stays closed, the scanner goes on and reports that other key.
- R8: While `key_held` is high, `key_code` keeps its latched value. Closing further keys in the frozen column does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| step_en | input | 1 | One-cycle scan step enable |
| row_in | input | 4 | Raw row lines, active high (pull-down) |
| col_drive | output | 4 | Column drive, one-hot, active high |
| key_code | output | 4 | Hex code of the key found |
| key_held | output | 1 | High from detection until release |

## Verification
The bench builds the scanner with its default of two synchronizer stages. It issues `step_en` once every eight clocks instead of at a rate of a few hundred hertz. With that rate, a full sweep of the four columns takes 32 clocks, so every one of the sixteen keys can be found and released many times within a short run. A behavioral key matrix joins each row to the columns of the keys that are closed. This lets the bench test column freezing, priority between rows, and the hand-off between keys held in two columns.

// File: rtl/kms_pkg.sv
package kms_pkg;
  localparam int unsigned KP_ROWS = 4;
  localparam int unsigned KP_COLS = 4;
  localparam int unsigned ROW_W   = $clog2(KP_ROWS);
  localparam int unsigned COL_W   = $clog2(KP_COLS);
  localparam int unsigned CODE_W  = 4;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_HOLD = 1'b1
  } scan_state_e;
endpackage

// File: rtl/kms_rst_sync.sv
module kms_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/kms_row_sync.sv
module kms_row_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/kms_key_decode.sv
module kms_key_decode
  import kms_pkg::*;
(
  input  logic [KP_ROWS-1:0] rows,
  input  logic [COL_W-1:0]   col,
  output logic               hit,
  output logic [CODE_W-1:0]  code
);
  logic [ROW_W-1:0] sel_row;
  logic [3:0]       r4;
  logic [3:0]       c4;

  // lowest-numbered active row wins (loop runs downward)
  always_comb begin
    sel_row = '0;
    for (int r = KP_ROWS - 1; r >= 0; r--) begin
      if (rows[r]) sel_row = ROW_W'(r);
    end
  end

  assign hit = |rows;
  assign r4  = 4'(sel_row);
  assign c4  = 4'(col);

  always_comb begin
    if (c4 == 4'd3) begin
      code = 4'hA + r4;
    end else if (r4 == 4'd3) begin
      case (c4)
        4'd0:    code = 4'hE;
        4'd1:    code = 4'h0;
        default: code = 4'hF;
      endcase
    end else begin
      code = r4 * 4'd3 + c4 + 4'd1;
    end
  end
endmodule

// File: rtl/kms_scan_fsm.sv
module kms_scan_fsm
  import kms_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [KP_ROWS-1:0] rows_s,
  input  logic               hit,
  input  logic [CODE_W-1:0]  code_in,
  output logic [COL_W-1:0]   col_q,
  output scan_state_e        state_q,
  output logic [CODE_W-1:0]  code_q
);
  scan_state_e       state_d;
  logic [COL_W-1:0]  col_d;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    code_d  = code_q;
    if (step_en) begin
      case (state_q)
        ST_SCAN: begin
          if (hit) begin
            state_d = ST_HOLD;
            code_d  = code_in;
          end else if (col_q == COL_W'(KP_COLS - 1)) begin
            col_d = '0;
          end else begin
            col_d = col_q + COL_W'(1);
          end
        end
        ST_HOLD: begin
          if (!(|rows_s)) state_d = ST_SCAN;
        end
        default: state_d = ST_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SCAN;
      col_q   <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      code_q  <= code_d;
    end
  end

  // R2: no column movement without a step
  p_no_step_no_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(col_q));

  // R3: column frozen while holding
  p_col_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> $stable(col_q));

  // R3: a hold only starts from an active row
  p_hold_needs_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_HOLD) |-> ($past(rows_s) != '0));

  // R6: stays held while a row is active
  p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && rows_s != '0) |=> (state_q == ST_HOLD));

  // R6: release on an idle step
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && step_en && rows_s == '0) |=> (state_q == ST_SCAN));

  // R8: latched code does not move during hold
  p_code_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> $stable(code_q));
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
  import kms_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [KP_ROWS-1:0] row_in,
  output logic [KP_COLS-1:0] col_drive,
  output logic [CODE_W-1:0]  key_code,
  output logic               key_held
);
  logic               srst_n;
  logic [KP_ROWS-1:0] rows_s;
  logic               hit;
  logic [CODE_W-1:0]  dec_code;
  logic [COL_W-1:0]   col_idx;
  scan_state_e        state;

  kms_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  kms_row_sync #(.WIDTH(KP_ROWS), .STAGES(SYNC_STAGES)) i_row_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (row_in),
    .dout  (rows_s)
  );

  kms_key_decode i_key_decode (
    .rows (rows_s),
    .col  (col_idx),
    .hit  (hit),
    .code (dec_code)
  );

  kms_scan_fsm i_scan_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .step_en (step_en),
    .rows_s  (rows_s),
    .hit     (hit),
    .code_in (dec_code),
    .col_q   (col_idx),
    .state_q (state),
    .code_q  (key_code)
  );

  for (genvar c = 0; c < KP_COLS; c++) begin : g_col
    assign col_drive[c] = (col_idx == COL_W'(c));
  end

  assign key_held = (state == ST_HOLD);

  // R2: exactly one column driven
  p_one_col_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(col_drive) == 1);
endmodule

// File: tb/test_keymatrix_scanner.sv
module test_keymatrix_scanner;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en;
  logic [3:0] row_in;
  logic [3:0] col_drive;
  logic [3:0] key_code;
  logic       key_held;

  logic [15:0] keys;   // bit r*4+c = key at row r, column c closed
  logic        gen_on;
  int          checks = 0;
  int          errors = 0;

  keymatrix_scanner i_keymatrix_scanner (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .row_in    (row_in),
    .col_drive (col_drive),
    .key_code  (key_code),
    .key_held  (key_held)
  );

  always #10 clk = ~clk;

  always_comb begin
    for (int r = 0; r < 4; r++) row_in[r] = |(keys[r*4 +: 4] & col_drive);
  end

  initial begin
    step_en = 1'b0;
    forever begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        step_en = gen_on && (k == 7);
      end
    end
  end

  function automatic logic [3:0] exp_code(input int r, input int c);
    logic [3:0] t [16];
    t = '{4'h1, 4'h2, 4'h3, 4'hA,
          4'h4, 4'h5, 4'h6, 4'hB,
          4'h7, 4'h8, 4'h9, 4'hC,
          4'hE, 4'h0, 4'hF, 4'hD};
    return t[r*4 + c];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; keys = '0; gen_on = 1'b0;
    cyc(4);
    chk("R1 col in reset", {4'h0, col_drive}, 8'h01);
    chk("R1 held in reset", {7'h0, key_held}, 8'h00);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 col after reset", {4'h0, col_drive}, 8'h01);
    chk("R1 code after reset", {4'h0, key_code}, 8'h00);
  endtask

  task automatic t_rotate;
    logic [3:0] prev;
    gen_on = 1'b1;
    for (int i = 0; i < 5; i++) begin
      do @(negedge clk); while (!step_en);
      prev = col_drive;
      @(negedge clk);
      chk("R2 rotate", {4'h0, col_drive}, {4'h0, prev[2:0], prev[3]});
    end
    gen_on = 1'b0;
    cyc(2);
    prev = col_drive;
    cyc(30);
    chk("R2 no step no move", {4'h0, col_drive}, {4'h0, prev});
    gen_on = 1'b1;
  endtask

  task automatic t_release(input string req);
    logic [3:0] frozen;
    frozen = col_drive;
    keys = '0;
    cyc(12);
    chk({req, " held drops"}, {7'h0, key_held}, 8'h00);
    cyc(12);
    chk({req, " rotation resumes"}, {7'h0, col_drive != frozen}, 8'h01);
  endtask

  task automatic t_all_keys;
    logic [3:0] frozen;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        keys = 16'(1) << (r*4 + c);
        cyc(60);
        chk("R3 held", {7'h0, key_held}, 8'h01);
        chk("R4 code", {4'h0, key_code}, {4'h0, exp_code(r, c)});
        chk("R3 column frozen", {4'h0, col_drive}, {4'h0, 4'(1) << c});
        frozen = col_drive;
        cyc(40);
        chk("R3 column still frozen", {4'h0, col_drive}, {4'h0, frozen});
        t_release("R6");
      end
    end
  endtask

  task automatic t_priority;
    keys = '0;
    keys[2*4 + 1] = 1'b1;
    keys[0*4 + 1] = 1'b1;
    cyc(60);
    chk("R5 lowest row wins", {4'h0, key_code}, 8'h02);
    t_release("R5");
  endtask

  task automatic t_extra_same_col;
    keys = '0;
    keys[2*4 + 3] = 1'b1;
    cyc(60);
    chk("R8 first key", {4'h0, key_code}, 8'h0C);
    keys[0*4 + 3] = 1'b1;
    cyc(40);
    chk("R8 code kept", {4'h0, key_code}, 8'h0C);
    chk("R8 still held", {7'h0, key_held}, 8'h01);
    t_release("R8");
  endtask

  task automatic t_two_cols;
    keys = '0;
    keys[0*4 + 0] = 1'b1;
    cyc(60);
    chk("R7 first key", {4'h0, key_code}, 8'h01);
    keys[1*4 + 2] = 1'b1;
    cyc(40);
    chk("R7 other column ignored", {4'h0, key_code}, 8'h01);
    chk("R3 frozen on column 0", {4'h0, col_drive}, 8'h01);
    keys[0*4 + 0] = 1'b0;
    cyc(80);
    chk("R7 hand-off code", {4'h0, key_code}, 8'h06);
    chk("R7 hand-off held", {7'h0, key_held}, 8'h01);
    t_release("R7");
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_rotate();
    t_all_keys();
    t_priority();
    t_extra_same_col();
    t_two_cols();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    report();
  end
endmodule